// File: doc/BRIEF.md
# Armed Output Frame Pulse Aligner

This block derives an output frame pulse from the output clock by integer division: one pulse for every M output clock cycles. A frame marker arriving from elsewhere (nominally a 2 kHz or 8 kHz stream, asynchronous to the output clock) can pull the phase of that pulse into line. Each realignment reloads the divider, so the next output pulse appears within a fixed number of output clock cycles after the input rising edge. The resolution is one output clock period.

Realignment only happens when the function is enabled, the upstream steering logic reports a valid input pair, and the block is armed. The arm source is either an active-low pin or an active-high software bit, chosen by a select input. In level mode every qualified input rising edge realigns the divider. In one-shot mode only the first qualified edge after arming does. After that the divider runs free until the block is disarmed and armed again. A status flag reports that an alignment has happened since the last arming.

All control inputs are synchronous to the output clock. Only the incoming frame marker is treated as asynchronous.

Top module: `frame_pulse_aligner`

## Requirements
- R1: While reset is high, and in the first cycle after it, `frame_out` and `aligned` are 0. The divide counter restarts at phase 0.
- R2: With no realignment, `frame_out` is high for exactly one cycle every M cycles, with M taken from `div_m`. A `div_m` value of 0 or 1 acts as M = 2.
- R3: Suppose `frame_in` is first sampled high at clock edge n and a realignment is qualified. Then `frame_out` is high in the cycle after edge n+2, and the following pulses come every M cycles from there.
- R4: With `fs_enable` = 0, `frame_in` has no effect on `frame_out` and `aligned` stays 0.
- R5: `arm_sel` = 0 arms the block while `arm_pin_n` = 0. `arm_sel` = 1 arms it while `arm_soft` = 1. The source that is not selected has no effect.
- R6: In level mode (`one_shot` = 0), every qualified rising edge of `frame_in` realigns the divider.
- R7: In one-shot mode (`one_shot` = 1), only the first qualified rising edge after arming realigns the divider. Later edges are ignored until the block is disarmed and armed again.
- R8: With `sel_valid` = 0, rising edges of `frame_in` have no effect on `frame_out` or `aligned`.
- R9: `aligned` rises in the same cycle as the pulse of the first realignment after arming. It falls in the cycle after a clock edge at which the block is not armed.
- R10: A `frame_in` level that stays high for many cycles causes only one realignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_in | input | 1 | Selected input frame marker, asynchronous |
| sel_valid | input | 1 | Steering logic reports a valid selected pair |
| fs_enable | input | 1 | Enables the alignment function |
| arm_sel | input | 1 | Arm source: 0 = pin, 1 = software bit |
| arm_pin_n | input | 1 | Arm pin, low means armed |
| arm_soft | input | 1 | Software arm bit, high means armed |
| one_shot | input | 1 | 1 = one-shot alignment, 0 = level mode |
| div_m | input | CNT_W | Clock-to-frame ratio M |
| frame_out | output | 1 | Output frame pulse, one cycle wide |
| aligned | output | 1 | An alignment has happened since arming |

## Verification
The bench keeps the default 16-bit counter width and drives small ratios, between 0 and 9. This lets many complete frame periods, wrap points and realignments at arbitrary phases fit into a short run. It also reaches the clamp of M values 0 and 1 and a change of M in the middle of a count. Input marks of one cycle, of a few cycles and of thirty cycles, which is longer than a frame, cover edge detection against level holding. Both arm sources and both alignment modes are toggled, and each is compared with an independent per-cycle model.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int DEF_CNT_W = 16;
  localparam int DEF_SYNC_STAGES = 2;

  typedef enum logic { ARM_FROM_PIN = 1'b0, ARM_FROM_SOFT = 1'b1 } arm_src_e;
endpackage

// File: rtl/fpa_edge_sync.sv
module fpa_edge_sync #(
  parameter int STAGES = fpa_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("fpa_edge_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[LAST-1:0], din};
  end

  // chain_q[LAST-1] is the synchronized level, chain_q[LAST] its previous value
  assign rise_o = chain_q[LAST-1] & ~chain_q[LAST];
endmodule

// File: rtl/fpa_arm_ctrl.sv
module fpa_arm_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic sel_valid_i,
  input  logic enable_i,
  input  logic arm_sel_i,
  input  logic arm_pin_n_i,
  input  logic arm_soft_i,
  input  logic one_shot_i,
  output logic realign_o,
  output logic aligned_o
);
  import fpa_pkg::*;

  logic armed;
  logic done_q;

  always_comb begin
    if (arm_src_e'(arm_sel_i) == ARM_FROM_SOFT) armed = enable_i & arm_soft_i;
    else                                        armed = enable_i & ~arm_pin_n_i;
  end

  assign realign_o = rise_i & sel_valid_i & armed & (~one_shot_i | ~done_q);

  always_ff @(posedge clk) begin
    if (rst)         done_q <= 1'b0;
    else if (!armed) done_q <= 1'b0;
    else if (realign_o) done_q <= 1'b1;
  end

  assign aligned_o = done_q;

  p_disarm_clears_r9: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !aligned_o);

  p_disabled_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> !aligned_o);

  p_invalid_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (!sel_valid_i && !aligned_o) |=> !aligned_o);
endmodule

// File: rtl/fpa_divider.sv
module fpa_divider #(
  parameter int CNT_W = fpa_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] div_m_i,
  input  logic             realign_i,
  output logic             frame_o
);
  localparam logic [CNT_W-1:0] MIN_M = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] m_eff;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign m_eff = (div_m_i < MIN_M) ? MIN_M : div_m_i;
  assign wrap  = (cnt_q >= m_eff - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      frame_o <= 1'b0;
    end else if (realign_i || wrap) begin
      cnt_q   <= '0;
      frame_o <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + ONE;
      frame_o <= 1'b0;
    end
  end

  p_realign_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    realign_i |=> frame_o);

  p_pulse_then_low_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_o && !realign_i && m_eff > MIN_M) |=> !frame_o);
endmodule

// File: rtl/frame_pulse_aligner.sv
module frame_pulse_aligner #(
  parameter int CNT_W       = fpa_pkg::DEF_CNT_W,
  parameter int SYNC_STAGES = fpa_pkg::DEF_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_in,
  input  logic             sel_valid,
  input  logic             fs_enable,
  input  logic             arm_sel,
  input  logic             arm_pin_n,
  input  logic             arm_soft,
  input  logic             one_shot,
  input  logic [CNT_W-1:0] div_m,
  output logic             frame_out,
  output logic             aligned
);
  logic rise;
  logic realign;

  fpa_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (frame_in),
    .rise_o (rise)
  );

  fpa_arm_ctrl u_arm (
    .clk         (clk),
    .rst         (rst),
    .rise_i      (rise),
    .sel_valid_i (sel_valid),
    .enable_i    (fs_enable),
    .arm_sel_i   (arm_sel),
    .arm_pin_n_i (arm_pin_n),
    .arm_soft_i  (arm_soft),
    .one_shot_i  (one_shot),
    .realign_o   (realign),
    .aligned_o   (aligned)
  );

  fpa_divider #(.CNT_W(CNT_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .div_m_i   (div_m),
    .realign_i (realign),
    .frame_o   (frame_out)
  );

  // R7: once aligned in one-shot mode, no further realignment may fire
  p_single_shot_r7: assert property (@(posedge clk) disable iff (rst)
    (one_shot && aligned) |-> !realign);
endmodule

// File: tb/sim_frame_pulse_aligner.sv
module sim_frame_pulse_aligner;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_in = 1'b0, sel_valid = 1'b1, fs_enable = 1'b0;
  logic arm_sel = 1'b0, arm_pin_n = 1'b1, arm_soft = 1'b0, one_shot = 1'b0;
  logic [CNT_W-1:0] div_m = 16'd5;
  logic frame_out, aligned;

  int checks = 0, fails = 0, cyc = 0;
  bit started = 0;
  string cur_req = "R1";

  frame_pulse_aligner #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .frame_in(frame_in), .sel_valid(sel_valid),
    .fs_enable(fs_enable), .arm_sel(arm_sel), .arm_pin_n(arm_pin_n),
    .arm_soft(arm_soft), .one_shot(one_shot), .div_m(div_m),
    .frame_out(frame_out), .aligned(aligned));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: history of sampled marker, phase counter, flag
  bit hist[$];
  int phase = 0;
  bit exp_out = 0, exp_al = 0;

  always @(posedge clk) begin
    bit armed, edge_seen, fire;
    int m;
    started = 1;
    cyc++;
    if (rst) begin
      hist = '{0, 0, 0, 0};
      phase = 0; exp_out = 0; exp_al = 0;
    end else begin
      hist.push_front(frame_in);
      void'(hist.pop_back());
      edge_seen = hist[2] && !hist[3];
      armed = fs_enable && (arm_sel ? arm_soft : !arm_pin_n);
      m = (int'(div_m) < 2) ? 2 : int'(div_m);
      fire = edge_seen && sel_valid && armed && (!one_shot || !exp_al);
      if (fire || phase >= m - 1) begin
        phase = 0; exp_out = 1;
      end else begin
        phase++; exp_out = 0;
      end
      if (!armed) exp_al = 0;
      else if (fire) exp_al = 1;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (frame_out !== exp_out || aligned !== exp_al) begin
        fails++;
        $display("FAIL %s cycle %0d: frame_out=%b aligned=%b expected %b %b",
                 cur_req, cyc, frame_out, aligned, exp_out, exp_al);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mark(input int hi, input int gap);
    frame_in = 1'b1; wait_n(hi);
    frame_in = 1'b0; wait_n(gap);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait_n(3);
    cur_req = "R1";
    chk("R1", frame_out, 1'b0);
    chk("R1", aligned, 1'b0);
    rst = 1'b0;
    wait_n(1);
    chk("R1", frame_out, 1'b0);

    cur_req = "R2"; wait_n(20);
    div_m = 16'd3; wait_n(10);

    cur_req = "R4"; arm_pin_n = 1'b0;
    mark(1, 6); mark(2, 9);
    chk("R4", aligned, 1'b0);

    cur_req = "R5"; div_m = 16'd6; fs_enable = 1'b1;
    arm_pin_n = 1'b1; arm_soft = 1'b1;
    mark(1, 8);
    chk("R5", aligned, 1'b0);
    arm_sel = 1'b1; arm_soft = 1'b0; arm_pin_n = 1'b0;
    mark(1, 8);
    chk("R5", aligned, 1'b0);
    arm_soft = 1'b1;
    mark(1, 8);
    chk("R5", aligned, 1'b1);

    cur_req = "R3"; arm_sel = 1'b0; div_m = 16'd9;
    wait_n(4);
    frame_in = 1'b1; wait_n(1); frame_in = 1'b0;
    wait_n(2);
    chk("R3", frame_out, 1'b1);
    cur_req = "R2"; wait_n(8);
    chk("R2", frame_out, 1'b0);
    wait_n(1);
    chk("R2", frame_out, 1'b1);

    cur_req = "R6"; div_m = 16'd7;
    mark(1, 11); mark(1, 4); mark(2, 17); mark(1, 2);

    cur_req = "R8"; sel_valid = 1'b0; arm_pin_n = 1'b1; wait_n(2); arm_pin_n = 1'b0;
    mark(1, 5); mark(1, 10);
    chk("R8", aligned, 1'b0);
    sel_valid = 1'b1;

    cur_req = "R10"; div_m = 16'd4;
    mark(30, 10);

    cur_req = "R7"; one_shot = 1'b1; arm_sel = 1'b1; arm_soft = 1'b0; div_m = 16'd8;
    wait_n(3); arm_soft = 1'b1;
    mark(1, 5); mark(1, 7); mark(2, 11);
    chk("R7", aligned, 1'b1);
    cur_req = "R9"; arm_soft = 1'b0; wait_n(2);
    chk("R9", aligned, 1'b0);
    cur_req = "R7"; arm_soft = 1'b1;
    mark(1, 3); mark(1, 9);

    cur_req = "R2"; one_shot = 1'b0; div_m = 16'd1; wait_n(10);
    div_m = 16'd0; wait_n(10);
    div_m = 16'd9; wait_n(5); div_m = 16'd3; wait_n(10);

    cur_req = "R1"; rst = 1'b1; wait_n(2);
    chk("R1", frame_out, 1'b0);
    chk("R1", aligned, 1'b0);
    rst = 1'b0; wait_n(5);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule